// File: doc/BRIEF.md
# Banked Register File with Upper-RAM Protection

This block is the 256-byte register space of a small 8-bit controller. A pointer byte held inside the space decides how short addresses are formed and which peripheral bank, if any, overlays the bottom of the map. An access arrives either as a 4-bit working-register number, which is placed inside the sixteen-byte group picked by the pointer's upper nibble, or as a full 8-bit absolute address. The bank swap is applied after this resolution. When the pointer's lower nibble is nonzero, resolved locations 00h-0Fh leave ordinary storage and reach a sixteen-register bank. Only bank 15 has storage: a data, a direction and a mode register.

A protection window can close the upper part of RAM. It is built in only when a parameter allows it. At run time it follows one bit of an interrupt-mask byte that also lives in the control area. A blocked access reads as all ones, changes nothing, and raises a one-cycle flag. Writes land on the clock edge. Reads are combinational.

Top module: `bank_regfile`

## Requirements
- R1: In working mode, the resolved address is {pointer[7:4], acc_addr[3:0]}; the upper bits of acc_addr are ignored.
- R2: In absolute mode, acc_addr is used unchanged. With pointer[3:0] = 0, locations 00h-0Fh are ordinary storage that reads back the last value written.
- R3: With pointer[3:0] = Fh, resolved locations 02h, 03h and 09h are the bank registers for port data, port direction and port mode. They read back what was written, and they drive p4_data_o, p4_dir_o and p6_mode_o.
- R4: With pointer[3:0] = Fh, every other resolved location in 00h-0Fh reads 00h, and writes to it change nothing.
- R5: With pointer[3:0] in 1h-Eh, resolved locations 00h-0Fh read 00h and ignore writes. The ordinary storage underneath is unchanged when bank 0 is selected again.
- R6: The swap acts on the resolved address. With the pointer at 1Fh, working register 2 reaches ordinary location 12h, while absolute address 02h reaches the port data register.
- R7: When PROT_EN = 1 and interrupt-mask bit 6 = 1, resolved addresses 80h-EFh are blocked. A read returns FFh and a write leaves the location unchanged. Clearing bit 6 removes the block.
- R8: Resolved addresses 00h-7Fh and F0h-FFh are never blocked.
- R9: prot_viol is high in the cycle after an edge at which a read or write hit a blocked address, and low after every other edge.
- R10: The pointer sits at FDh and the interrupt mask at FBh. Both reset to 00h, read back what was written, and appear on ptr_o and imsk_o.
- R11: A write takes effect at the rising clock edge. A read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wreg | input | 1 | 1 = working-register address, 0 = absolute address |
| acc_addr | input | 8 | Access address (low 4 bits used in working mode) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| prot_viol | output | 1 | One-cycle pulse after a blocked access |
| ptr_o | output | 8 | Current pointer byte |
| imsk_o | output | 8 | Current interrupt-mask byte |
| p4_data_o | output | 8 | Bank-15 port data register |
| p4_dir_o | output | 8 | Bank-15 port direction register |
| p6_mode_o | output | 8 | Bank-15 port mode register |

## Verification
The assertions assume a known reset is applied before any access. They also assume the strobes and the address are held steady across each rising edge, so the registered violation flag and the combinational read path see the same access. The bench drives all inputs at the falling edge and drops both strobes right after each rising edge. Its random stream can rewrite the pointer and the mask at any time, so every bank and protection combination is reached through the normal write path.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
   localparam int RF_AW  = 8;
   localparam int RF_DW  = 8;
   localparam int RF_NIB = 4;

   typedef struct packed {
      logic [RF_AW-1:0]  addr;
      logic              xbank;
      logic [RF_NIB-1:0] bank;
   } rf_loc_t;
endpackage

// File: rtl/rfb_addr_map.sv
module rfb_addr_map
   import rfb_pkg::*;
#(
   parameter int AW  = RF_AW,
   parameter int NIB = RF_NIB
) (
   input  logic [AW-1:0] ptr,
   input  logic          wreg,
   input  logic [AW-1:0] raw,
   output rf_loc_t       loc
);
   localparam int GRP_W = AW - NIB;

   if (AW != RF_AW || NIB != RF_NIB) begin : g_chk
      $error("rfb_addr_map: widths must match rfb_pkg");
   end

   logic [AW-1:0]  resolved;
   logic [NIB-1:0] bank_sel;

   assign bank_sel = ptr[NIB-1:0];

   always_comb begin
      if (wreg) resolved = {ptr[AW-1 -: GRP_W], raw[NIB-1:0]};
      else      resolved = raw;
   end

   always_comb begin
      loc.addr  = resolved;
      loc.bank  = bank_sel;
      loc.xbank = (resolved[AW-1:NIB] == '0) && (bank_sel != '0);
   end
endmodule

// File: rtl/rfb_guard.sv
module rfb_guard #(
   parameter int       AW       = 8,
   parameter int       DW       = 8,
   parameter bit       PROT_EN  = 1'b1,
   parameter int       PROT_BIT = 6,
   parameter logic [7:0] WIN_LO = 8'h80,
   parameter logic [7:0] WIN_HI = 8'hEF
) (
   input  logic [DW-1:0] imsk,
   input  logic [AW-1:0] addr,
   output logic          blk
);
   if (PROT_BIT >= DW) begin : g_bit_chk
      $error("rfb_guard: PROT_BIT outside mask width");
   end
   if (WIN_LO > WIN_HI) begin : g_win_chk
      $error("rfb_guard: empty protect window");
   end

   if (PROT_EN) begin : g_gate
      logic in_win;
      assign in_win = (addr >= AW'(WIN_LO)) && (addr <= AW'(WIN_HI));
      assign blk    = imsk[PROT_BIT] && in_win;
   end else begin : g_open
      assign blk = 1'b0;
   end

   // control area above the window never blocked (R8)
   always_comb begin
      if (addr > AW'(WIN_HI))
         a_ctrl_open_r8: assert (!blk);
   end
endmodule

// File: rtl/rfb_xbank.sv
module rfb_xbank #(
   parameter int NIB      = 4,
   parameter int DW       = 8,
   parameter int LOC_DATA = 2,
   parameter int LOC_DIR  = 3,
   parameter int LOC_MODE = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [NIB-1:0] loc,
   input  logic [DW-1:0]  wd,
   output logic [DW-1:0]  rd,
   output logic [DW-1:0]  data_q,
   output logic [DW-1:0]  dir_q,
   output logic [DW-1:0]  mode_q
);
   localparam int NLOC = 1 << NIB;

   if (LOC_DATA >= NLOC || LOC_DIR >= NLOC || LOC_MODE >= NLOC) begin : g_chk
      $error("rfb_xbank: register location outside bank");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         mode_q <= '0;
      end else if (we) begin
         if (loc == NIB'(LOC_DATA)) data_q <= wd;
         if (loc == NIB'(LOC_DIR))  dir_q  <= wd;
         if (loc == NIB'(LOC_MODE)) mode_q <= wd;
      end
   end

   always_comb begin
      rd = '0;
      if (loc == NIB'(LOC_DATA)) rd = data_q;
      if (loc == NIB'(LOC_DIR))  rd = dir_q;
      if (loc == NIB'(LOC_MODE)) rd = mode_q;
   end

   // registers only move on a write (R3)
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(data_q) && $stable(dir_q) && $stable(mode_q)));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
   import rfb_pkg::*;
#(
   parameter bit         PROT_EN   = 1'b1,
   parameter int         PROT_BIT  = 6,
   parameter logic [7:0] WIN_LO    = 8'h80,
   parameter logic [7:0] WIN_HI    = 8'hEF,
   parameter logic [7:0] PTR_ADDR  = 8'hFD,
   parameter logic [7:0] IMSK_ADDR = 8'hFB,
   parameter int         IMPL_BANK = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_wreg,
   input  logic [RF_AW-1:0] acc_addr,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [RF_DW-1:0] wdata,
   output logic [RF_DW-1:0] rdata,
   output logic             prot_viol,
   output logic [RF_DW-1:0] ptr_o,
   output logic [RF_DW-1:0] imsk_o,
   output logic [RF_DW-1:0] p4_data_o,
   output logic [RF_DW-1:0] p4_dir_o,
   output logic [RF_DW-1:0] p6_mode_o
);
   localparam int DEPTH = 1 << RF_AW;

   if (PTR_ADDR == IMSK_ADDR) begin : g_ctl_chk
      $error("bank_regfile: pointer and mask share an address");
   end
   if (IMPL_BANK == 0 || IMPL_BANK >= (1 << RF_NIB)) begin : g_bank_chk
      $error("bank_regfile: implemented bank must be 1..15");
   end

   logic [RF_DW-1:0] ptr_q, imsk_q;
   logic [RF_DW-1:0] mem [DEPTH];
   rf_loc_t          loc;
   logic             blk, xb_hit, xb_we, ram_we;
   logic [RF_DW-1:0] xb_rd;

   rfb_addr_map #(.AW(RF_AW), .NIB(RF_NIB)) u_map (
      .ptr  (ptr_q),
      .wreg (acc_wreg),
      .raw  (acc_addr),
      .loc  (loc)
   );

   rfb_guard #(
      .AW(RF_AW), .DW(RF_DW), .PROT_EN(PROT_EN), .PROT_BIT(PROT_BIT),
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) u_guard (
      .imsk (imsk_q),
      .addr (loc.addr),
      .blk  (blk)
   );

   assign xb_hit = loc.xbank && (loc.bank == RF_NIB'(IMPL_BANK));
   assign xb_we  = wr_en && xb_hit;
   assign ram_we = wr_en && !blk && !loc.xbank;

   rfb_xbank #(.NIB(RF_NIB), .DW(RF_DW)) u_xbank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (xb_we),
      .loc    (loc.addr[RF_NIB-1:0]),
      .wd     (wdata),
      .rd     (xb_rd),
      .data_q (p4_data_o),
      .dir_q  (p4_dir_o),
      .mode_q (p6_mode_o)
   );

   always_ff @(posedge clk) begin
      if (ram_we) mem[loc.addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         imsk_q <= '0;
      end else if (ram_we) begin
         if (loc.addr == PTR_ADDR)  ptr_q  <= wdata;
         if (loc.addr == IMSK_ADDR) imsk_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prot_viol <= 1'b0;
      else        prot_viol <= (rd_en || wr_en) && blk;
   end

   always_comb begin
      if (blk)                         rdata = '1;
      else if (loc.xbank)              rdata = xb_hit ? xb_rd : '0;
      else if (loc.addr == PTR_ADDR)   rdata = ptr_q;
      else if (loc.addr == IMSK_ADDR)  rdata = imsk_q;
      else                             rdata = mem[loc.addr];
   end

   assign ptr_o  = ptr_q;
   assign imsk_o = imsk_q;

   // blocked read shows all ones (R7)
   always_comb begin
      if (rst_n && rd_en && blk)
         a_blk_read_r7: assert (rdata == '1);
   end

   // unimplemented bank reads zero (R5)
   always_comb begin
      if (rst_n && rd_en && loc.xbank && !xb_hit)
         a_unimpl_zero_r5: assert (rdata == '0);
   end

   // flag only follows a blocked access (R9)
   p_viol_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prot_viol |-> $past((rd_en || wr_en) && blk));

   // blocked write cannot move the control bytes (R7)
   p_blk_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && blk) |=> ($stable(ptr_q) && $stable(imsk_q)));
endmodule

// File: tb/bank_regfile_tb.sv
`timescale 1ns/1ps
module bank_regfile_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_wreg = 1'b0;
   logic [7:0] acc_addr = '0;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, ptr_o, imsk_o, p4_data_o, p4_dir_o, p6_mode_o;
   logic       prot_viol;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_mem [256];
   logic [7:0] m_ptr = '0, m_imsk = '0, m_dat = '0, m_dir = '0, m_mode = '0;

   always #2 clk = ~clk;

   bank_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .acc_wreg(acc_wreg), .acc_addr(acc_addr),
      .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .prot_viol(prot_viol), .ptr_o(ptr_o), .imsk_o(imsk_o),
      .p4_data_o(p4_data_o), .p4_dir_o(p4_dir_o), .p6_mode_o(p6_mode_o)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] resolve(input bit wr, input logic [7:0] a);
      return wr ? {m_ptr[7:4], a[3:0]} : a;
   endfunction

   function automatic bit swapped(input logic [7:0] res);
      return (res < 8'h10) && (m_ptr[3:0] != 4'h0);
   endfunction

   function automatic bit blocked(input logic [7:0] res);
      return m_imsk[6] && (res >= 8'h80) && (res <= 8'hEF);
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] res);
      if (blocked(res)) return 8'hFF;
      if (swapped(res)) begin
         if (m_ptr[3:0] != 4'hF) return 8'h00;
         case (res[3:0])
            4'h2: return m_dat;
            4'h3: return m_dir;
            4'h9: return m_mode;
            default: return 8'h00;
         endcase
      end
      if (res == 8'hFD) return m_ptr;
      if (res == 8'hFB) return m_imsk;
      return m_mem[res];
   endfunction

   function automatic string tag_of(input bit wr, input logic [7:0] res);
      if (blocked(res)) return "R7";
      if (swapped(res)) begin
         if (m_ptr[3:0] != 4'hF) return "R5";
         if (res[3:0] == 4'h2 || res[3:0] == 4'h3 || res[3:0] == 4'h9) return "R3";
         return "R4";
      end
      if (res >= 8'hF0) return "R8";
      return wr ? "R1" : "R2";
   endfunction

   task automatic model_write(input logic [7:0] res, input logic [7:0] d);
      if (blocked(res)) return;
      if (swapped(res)) begin
         if (m_ptr[3:0] == 4'hF) begin
            if (res[3:0] == 4'h2) m_dat  = d;
            if (res[3:0] == 4'h3) m_dir  = d;
            if (res[3:0] == 4'h9) m_mode = d;
         end
         return;
      end
      m_mem[res] = d;
      if (res == 8'hFD) m_ptr  = d;
      if (res == 8'hFB) m_imsk = d;
   endtask

   task automatic op(input bit wr, input logic [7:0] a, input bit r, input bit w,
                     input logic [7:0] d, input string tag);
      logic [7:0] res;
      bit         blk;
      @(negedge clk);
      acc_wreg = wr; acc_addr = a; rd_en = r; wr_en = w; wdata = d;
      res = resolve(wr, a);
      blk = blocked(res);
      #0.5;
      if (r) chk(rdata, exp_read(res), (tag == "") ? tag_of(wr, res) : tag);
      @(posedge clk);
      #0.5;
      rd_en = 1'b0; wr_en = 1'b0;
      if (w) model_write(res, d);
      chk({7'd0, prot_viol}, {7'd0, (r || w) && blk}, "R9");
      chk(ptr_o, m_ptr, "R10");
      chk(imsk_o, m_imsk, "R10");
      chk(p4_data_o, m_dat, "R3");
      chk(p4_dir_o, m_dir, "R3");
      chk(p6_mode_o, m_mode, "R3");
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #0.5;
      // reset state (R10)
      chk(ptr_o, 8'h00, "R10");
      chk(imsk_o, 8'h00, "R10");
      chk(p4_data_o, 8'h00, "R3");
      chk({7'd0, prot_viol}, 8'h00, "R9");
      rst_n = 1'b1;

      // fill ordinary storage, control bytes kept at zero
      for (int i = 0; i < 256; i++)
         op(1'b0, 8'(i), 1'b0, 1'b1,
            (i == 8'hFD || i == 8'hFB) ? 8'h00 : 8'(i * 7 + 3), "R2");
      op(1'b0, 8'h05, 1'b1, 1'b0, 8'h00, "R2");

      // R1: working group 3, register 5 -> 35h; upper raw bits ignored
      op(1'b0, 8'hFD, 1'b0, 1'b1, 8'h30, "R10");
      op(1'b1, 8'hA5, 1'b0, 1'b1, 8'h5A, "R1");
      op(1'b0, 8'h35, 1'b1, 1'b0, 8'h00, "R1");

      // R6: pointer 1Fh, working r2 -> 12h, absolute 02h -> port data
      op(1'b0, 8'hFD, 1'b0, 1'b1, 8'h1F, "R10");
      op(1'b1, 8'h02, 1'b0, 1'b1, 8'hD6, "R6");
      op(1'b0, 8'h02, 1'b0, 1'b1, 8'h96, "R6");
      op(1'b0, 8'h12, 1'b1, 1'b0, 8'h00, "R6");
      op(1'b0, 8'h02, 1'b1, 1'b0, 8'h00, "R6");
      op(1'b0, 8'h09, 1'b0, 1'b1, 8'hF0, "R3");
      op(1'b0, 8'h03, 1'b0, 1'b1, 8'h3C, "R3");
      op(1'b0, 8'h09, 1'b1, 1'b0, 8'h00, "R3");
      // R4: reserved locations in bank 15
      op(1'b0, 8'h00, 1'b0, 1'b1, 8'h77, "R4");
      op(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, "R4");
      op(1'b0, 8'h0E, 1'b1, 1'b1, 8'h44, "R4");

      // R5: bank 5 hides low locations, storage survives
      op(1'b0, 8'hFD, 1'b0, 1'b1, 8'h05, "R10");
      op(1'b0, 8'h03, 1'b0, 1'b1, 8'hEE, "R5");
      op(1'b0, 8'h03, 1'b1, 1'b0, 8'h00, "R5");
      op(1'b0, 8'hFD, 1'b0, 1'b1, 8'h00, "R10");
      op(1'b0, 8'h03, 1'b1, 1'b0, 8'h00, "R5");

      // R11: read in the write cycle sees old value, next cycle new
      op(1'b0, 8'h44, 1'b1, 1'b1, 8'hC3, "R11");
      op(1'b0, 8'h44, 1'b1, 1'b0, 8'h00, "R11");

      // R7/R8: protect on
      op(1'b0, 8'hFB, 1'b0, 1'b1, 8'h40, "R10");
      op(1'b0, 8'h90, 1'b1, 1'b0, 8'h00, "R7");
      op(1'b0, 8'h90, 1'b0, 1'b1, 8'h11, "R7");
      op(1'b0, 8'hEF, 1'b1, 1'b0, 8'h00, "R7");
      op(1'b0, 8'h80, 1'b1, 1'b0, 8'h00, "R7");
      op(1'b0, 8'h7F, 1'b1, 1'b0, 8'h00, "R8");
      op(1'b0, 8'hF0, 1'b1, 1'b1, 8'h21, "R8");
      op(1'b0, 8'hF0, 1'b1, 1'b0, 8'h00, "R8");
      op(1'b0, 8'hFB, 1'b0, 1'b1, 8'h00, "R7");
      op(1'b0, 8'h90, 1'b1, 1'b0, 8'h00, "R7");

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         bit         wr   = 1'($urandom);
         logic [7:0] a    = 8'($urandom);
         int unsigned sel = $urandom % 8;
         bit         r    = 1'($urandom);
         bit         w    = 1'($urandom);
         if (sel == 0) begin a = 8'hFD; wr = 1'b0; end
         else if (sel == 1) begin a = 8'hFB; wr = 1'b0; end
         else if (sel == 2) a = {4'h0, a[3:0]};
         op(wr, a, r, w, 8'($urandom), "");
      end

      repeat (2) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule